// File: doc/BRIEF.md
# DMA Channel Request Generator

This block is the request front end of one DMA channel. It decides, on every clock, whether the channel should ask the transfer engine for another transfer. It also reports which addressing form and which transfer direction the selected request code implies. Three kinds of requester are supported: an internal auto-request for memory-to-memory work or for peripherals that cannot ask, an external active-low request pin, and an on-chip peripheral request line. The requester need not be the source or destination of the data.

A channel may request only while its five enable terms agree. These are the channel enable, the master enable, a clear transfer-end flag, a clear NMI flag and a clear address-error flag. The external pin is synchronised and then detected either by level or by falling edge. In edge mode a pending bit holds one request until the engine acknowledges it. In level mode the pin is sampled again after a short blanking gap that follows each acknowledge.

Top module: `dma_req_gen`

## Requirements
- R1: `reqSel` chooses the requester: 4'b0100 is auto-request, 4'b1000 is the peripheral line, and 4'b0000, 4'b0010 and 4'b0011 are the external pin.
- R2: `reqOut` is 0 at the first rising edge after any enable term fails (`chanEn`=0, `masterEn`=0, `xferEnd`=1, `nmiFlag`=1 or `addrErr`=1). An edge-mode pending request is discarded at that edge and does not return when the enables come back.
- R3: With the enables met and auto-request selected, `reqOut` is 1 from the next rising edge and stays 1 through acknowledges.
- R4: `dreqN` passes through a two-stage synchroniser. In both detect modes, a low on `dreqN` driven before rising edge n makes `reqOut` 1 at edge n+2, and not earlier.
- R5: With `edgeMode`=1, a falling edge of the synchronised pin sets a pending request that `reqOut` shows. An `ack` clears it at the next edge. Further falling edges while the request is pending are not counted again.
- R6: With `edgeMode`=0, `reqOut` follows a low pin. After an `ack` seen at edge n, `reqOut` is 0 at edges n and n+1 and returns at n+2 only if the pin is still low. A high pin drops `reqOut` two edges after the synchroniser input rises.
- R7: With the peripheral line selected, `periphReq` is sampled without synchronisation: `reqOut` follows it one edge later, with the same two-edge blanking after an `ack` as in R6.
- R8: Every `reqSel` value not listed in R1 is reserved. It gives `selValid`=0 and never raises `reqOut`, whatever the pin and the peripheral line do.
- R9: The decode outputs are combinational from `reqSel`. Codes 4'b0000, 4'b0100 and 4'b1000 give `dualAddr`=1 and `dackToDev`=0. Code 4'b0010 gives `dualAddr`=0 and `dackToDev`=1 (memory to the acknowledged device). Code 4'b0011 gives `dualAddr`=0 and `dackToDev`=0 (device to memory).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanEn | input | 1 | Channel enable |
| xferEnd | input | 1 | Channel transfer-end flag |
| reqSel | input | 4 | Request-source and address-mode code |
| edgeMode | input | 1 | Pin detect: 0 low level, 1 falling edge |
| masterEn | input | 1 | Controller-wide enable |
| nmiFlag | input | 1 | Controller NMI flag |
| addrErr | input | 1 | Controller address-error flag |
| dreqN | input | 1 | External request pin, active low, asynchronous |
| periphReq | input | 1 | On-chip peripheral request, synchronous |
| ack | input | 1 | Per-transfer acknowledge from the engine |
| reqOut | output | 1 | Registered transfer request to the engine |
| dualAddr | output | 1 | 1 for dual-address mode |
| dackToDev | output | 1 | Single-address direction: 1 memory to device |
| selValid | output | 1 | `reqSel` is a defined code |

## Verification
The latencies differ by result. `reqOut` answers the enable terms, auto-request, `ack` and `periphReq` at the next rising edge. It answers `dreqN` two edges after the synchroniser captures it, and after an acknowledge in level modes it stays low for two edges. The decode outputs change in the same cycle as `reqSel`. The driver task records each expected `reqOut` value with its due cycle counted in rising edges from the stimulus. The monitor compares the value half a period after that edge. Decode outputs are compared one time unit after `reqSel` changes.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  localparam int SelW = 4;

  // Request-select codes; the datapath and decoder depend on these values
  localparam logic [SelW-1:0] SelPinDual   = 4'b0000;
  localparam logic [SelW-1:0] SelPinToDev  = 4'b0010;
  localparam logic [SelW-1:0] SelPinToMem  = 4'b0011;
  localparam logic [SelW-1:0] SelAuto      = 4'b0100;
  localparam logic [SelW-1:0] SelPeriph    = 4'b1000;

  // Strobes from the control decode to the request datapath
  typedef struct packed {
    logic gateOk;     // all five enable terms agree
    logic autoSel;    // internal auto-request
    logic dreqSel;    // external pin
    logic periphSel;  // on-chip peripheral line
    logic edgeSel;    // pin detected by falling edge
  } ctlStrobes_t;

endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            chanEn,
  input  logic            xferEnd,
  input  logic [SelW-1:0] reqSel,
  input  logic            edgeMode,
  input  logic            masterEn,
  input  logic            nmiFlag,
  input  logic            addrErr,
  output ctlStrobes_t     ctl,
  output logic            dualAddr,
  output logic            dackToDev,
  output logic            selValid
);

  logic autoDec, pinDec, perDec;

  always_comb begin
    autoDec   = 1'b0;
    pinDec    = 1'b0;
    perDec    = 1'b0;
    dualAddr  = 1'b0;
    dackToDev = 1'b0;
    selValid  = 1'b1;
    unique case (reqSel)
      SelPinDual:  begin pinDec = 1'b1; dualAddr = 1'b1; end
      SelPinToDev: begin pinDec = 1'b1; dackToDev = 1'b1; end
      SelPinToMem: begin pinDec = 1'b1; end
      SelAuto:     begin autoDec = 1'b1; dualAddr = 1'b1; end
      SelPeriph:   begin perDec = 1'b1; dualAddr = 1'b1; end
      default:     selValid = 1'b0;
    endcase
  end

  always_comb begin
    ctl.gateOk    = chanEn & masterEn & ~xferEnd & ~nmiFlag & ~addrErr;
    ctl.autoSel   = autoDec;
    ctl.dreqSel   = pinDec;
    ctl.periphSel = perDec;
    ctl.edgeSel   = edgeMode;
  end

  // R9: a single-address decode only comes from an external-pin code
  a_r9_single_is_pin: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && !dualAddr) |-> ctl.dreqSel);

endmodule

// File: rtl/dma_req_dpath.sv
module dma_req_dpath
  import dma_req_pkg::*;
#(
  parameter int SyncStages = 2
)(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic        dreqN,
  input  logic        periphReq,
  input  logic        ack,
  output logic        reqOut
);

  localparam int LastStage = SyncStages - 1;

  logic [SyncStages-1:0] syncQ;
  logic prevQ, pendQ, blankQ, reqQ;
  logic synced, fallNow, pendNext, levelHit, levelNext, autoNext, reqNext;

  // Synchroniser chain, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b1;
    else       syncQ[0] <= dreqN;
  end

  for (genvar gi = 1; gi < SyncStages; gi++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[gi] <= 1'b1;
      else       syncQ[gi] <= syncQ[gi-1];
    end
  end

  always_comb begin
    synced    = syncQ[LastStage];
    fallNow   = prevQ & ~synced;
    pendNext  = ctl.gateOk & ctl.dreqSel & ctl.edgeSel & (fallNow | (pendQ & ~ack));
    levelHit  = (ctl.dreqSel & ~ctl.edgeSel & ~synced) | (ctl.periphSel & periphReq);
    levelNext = ctl.gateOk & levelHit & ~ack & ~blankQ;
    autoNext  = ctl.gateOk & ctl.autoSel;
    reqNext   = autoNext | pendNext | levelNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= 1'b1;
      pendQ  <= 1'b0;
      blankQ <= 1'b0;
      reqQ   <= 1'b0;
    end else begin
      prevQ  <= synced;
      pendQ  <= pendNext;
      blankQ <= ack;
      reqQ   <= reqNext;
    end
  end

  assign reqOut = reqQ;

  // R2: losing any enable term withdraws the request at the next edge
  a_r2_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.gateOk |=> !reqOut);

  // R3: auto-request asserts continuously while enabled
  a_r3_auto_on: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.gateOk && ctl.autoSel) |=> reqOut);

  // R5: an acknowledge clears the edge-mode request unless a new edge arrives
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dreqSel && ctl.edgeSel && ack && !fallNow) |=> !reqOut);

  // R6: the blanking cycle after an acknowledge keeps level requests low
  a_r6_blank_low: assert property (@(posedge clk) disable iff (!rstN)
    (blankQ && !ctl.autoSel && !(ctl.dreqSel && ctl.edgeSel)) |=> !reqOut);

  // R8: a reserved code never produces a request
  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.autoSel || ctl.dreqSel || ctl.periphSel) |=> !reqOut);

endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int SyncStages = 2
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            chanEn,
  input  logic            xferEnd,
  input  logic [SelW-1:0] reqSel,
  input  logic            edgeMode,
  input  logic            masterEn,
  input  logic            nmiFlag,
  input  logic            addrErr,
  input  logic            dreqN,
  input  logic            periphReq,
  input  logic            ack,
  output logic            reqOut,
  output logic            dualAddr,
  output logic            dackToDev,
  output logic            selValid
);

  ctlStrobes_t ctl;

  dma_req_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chanEn    (chanEn),
    .xferEnd   (xferEnd),
    .reqSel    (reqSel),
    .edgeMode  (edgeMode),
    .masterEn  (masterEn),
    .nmiFlag   (nmiFlag),
    .addrErr   (addrErr),
    .ctl       (ctl),
    .dualAddr  (dualAddr),
    .dackToDev (dackToDev),
    .selValid  (selValid)
  );

  dma_req_dpath #(.SyncStages(SyncStages)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .dreqN     (dreqN),
    .periphReq (periphReq),
    .ack       (ack),
    .reqOut    (reqOut)
  );

endmodule

// File: tb/tb_dma_req_gen.sv
module tb_dma_req_gen;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, chanEn, xferEnd, edgeMode, masterEn, nmiFlag, addrErr;
  logic dreqN, periphReq, ack;
  logic [3:0] reqSel;
  logic reqOut, dualAddr, dackToDev, selValid;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    logic  val;
    string tag;
  } expItem_t;

  expItem_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_req_gen dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .xferEnd(xferEnd),
    .reqSel(reqSel), .edgeMode(edgeMode), .masterEn(masterEn),
    .nmiFlag(nmiFlag), .addrErr(addrErr), .dreqN(dreqN),
    .periphReq(periphReq), .ack(ack), .reqOut(reqOut),
    .dualAddr(dualAddr), .dackToDev(dackToDev), .selValid(selValid)
  );

  // Driver side: expected reqOut value, due d rising edges from now
  task automatic expectAt(input int d, input logic v, input string tag);
    sb.push_back('{cyc + d, v, tag});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkDec(input logic [3:0] sel, input logic eValid,
                          input logic eDual, input logic eDack, input string tag);
    reqSel = sel;
    #1;
    compared++;
    if ({selValid, dualAddr, dackToDev} !== {eValid, eDual, eDack}) begin
      mismatched++;
      $display("FAIL %s sel=%b valid/dual/dack=%b%b%b expected %b%b%b",
               tag, sel, selValid, dualAddr, dackToDev, eValid, eDual, eDack);
    end
  endtask

  // Monitor: compare due items away from the active edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        compared++;
        if (reqOut !== sb[i].val) begin
          mismatched++;
          $display("FAIL %s cycle %0d reqOut=%b expected %b",
                   sb[i].tag, cyc, reqOut, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finishRun();
  end

  initial begin
    rstN = 1'b0; chanEn = 1'b0; xferEnd = 1'b0; edgeMode = 1'b0;
    masterEn = 1'b0; nmiFlag = 1'b0; addrErr = 1'b0; dreqN = 1'b1;
    periphReq = 1'b0; ack = 1'b0; reqSel = 4'b0100;
    step(3);
    rstN = 1'b1;
    expectAt(1, 1'b0, "reset");
    step(2);

    // R1/R3: auto-request, held through an acknowledge
    chanEn = 1'b1; masterEn = 1'b1;
    expectAt(1, 1'b1, "R3 auto start");
    step(2);
    ack = 1'b1;
    expectAt(1, 1'b1, "R3 auto ack");
    expectAt(2, 1'b1, "R3 auto after ack");
    step(1);
    ack = 1'b0;
    step(2);

    // R2: each of the five enable terms blocks the request
    for (int t = 0; t < 5; t++) begin
      case (t)
        0: chanEn = 1'b0;
        1: masterEn = 1'b0;
        2: xferEnd = 1'b1;
        3: nmiFlag = 1'b1;
        default: addrErr = 1'b1;
      endcase
      expectAt(1, 1'b0, "R2 enable term off");
      step(2);
      chanEn = 1'b1; masterEn = 1'b1; xferEnd = 1'b0; nmiFlag = 1'b0; addrErr = 1'b0;
      expectAt(1, 1'b1, "R2 enable restored");
      step(2);
    end

    // R9/R8: decode of each code
    checkDec(4'b0000, 1'b1, 1'b1, 1'b0, "R9 pin dual");
    checkDec(4'b0010, 1'b1, 1'b0, 1'b1, "R9 mem to device");
    checkDec(4'b0011, 1'b1, 1'b0, 1'b0, "R9 device to mem");
    checkDec(4'b0100, 1'b1, 1'b1, 1'b0, "R9 auto dual");
    checkDec(4'b1000, 1'b1, 1'b1, 1'b0, "R9 periph dual");
    checkDec(4'b0001, 1'b0, 1'b0, 1'b0, "R8 reserved decode");
    checkDec(4'b1111, 1'b0, 1'b0, 1'b0, "R8 reserved decode");

    // R4/R6: level detection on the pin
    reqSel = 4'b0010; edgeMode = 1'b0;
    step(1);
    expectAt(2, 1'b0, "R6 idle pin");
    step(3);
    dreqN = 1'b0;
    expectAt(2, 1'b0, "R4 level not early");
    expectAt(3, 1'b1, "R4 level latency");
    step(5);
    ack = 1'b1;
    expectAt(1, 1'b0, "R6 ack drop");
    expectAt(2, 1'b0, "R6 blanking");
    expectAt(3, 1'b1, "R6 re-sample");
    step(1);
    ack = 1'b0;
    step(3);
    dreqN = 1'b1;
    expectAt(2, 1'b1, "R6 release pending");
    expectAt(3, 1'b0, "R6 release");
    step(4);

    // R4/R5: falling-edge detection
    reqSel = 4'b0011; edgeMode = 1'b1;
    step(1);
    dreqN = 1'b0;
    expectAt(2, 1'b0, "R4 edge not early");
    expectAt(3, 1'b1, "R5 edge latency");
    step(4);
    ack = 1'b1;
    expectAt(1, 1'b0, "R5 ack clears");
    expectAt(4, 1'b0, "R5 held low no re-request");
    step(1);
    ack = 1'b0;
    step(4);
    // two edges while pending, one acknowledge
    dreqN = 1'b1; step(2);
    dreqN = 1'b0;
    expectAt(3, 1'b1, "R5 first edge");
    step(3);
    dreqN = 1'b1; step(2);
    dreqN = 1'b0;
    step(4);
    ack = 1'b1;
    expectAt(1, 1'b0, "R5 second edge not counted");
    expectAt(4, 1'b0, "R5 second edge not counted later");
    step(1);
    ack = 1'b0;
    step(5);

    // R2: pending edge request discarded on enable loss
    dreqN = 1'b1; step(2);
    dreqN = 1'b0;
    expectAt(3, 1'b1, "R2 pending set");
    step(3);
    masterEn = 1'b0;
    expectAt(1, 1'b0, "R2 withdraw");
    step(1);
    masterEn = 1'b1;
    expectAt(1, 1'b0, "R2 pending discarded");
    expectAt(3, 1'b0, "R2 pending discarded later");
    step(4);

    // R1/R7: peripheral request line
    reqSel = 4'b1000; dreqN = 1'b1;
    periphReq = 1'b1;
    expectAt(1, 1'b1, "R7 periph latency");
    step(2);
    ack = 1'b1;
    expectAt(1, 1'b0, "R7 ack drop");
    expectAt(2, 1'b0, "R7 blanking");
    expectAt(3, 1'b1, "R7 re-sample");
    step(1);
    ack = 1'b0;
    step(3);
    periphReq = 1'b0;
    expectAt(1, 1'b0, "R7 release");
    step(2);

    // R8: reserved codes stay quiet under pin and peripheral activity
    reqSel = 4'b0001; edgeMode = 1'b0; dreqN = 1'b0; periphReq = 1'b1;
    expectAt(1, 1'b0, "R8 reserved quiet");
    expectAt(4, 1'b0, "R8 reserved quiet later");
    step(5);
    reqSel = 4'b1111; edgeMode = 1'b1; dreqN = 1'b1;
    step(2);
    dreqN = 1'b0;
    expectAt(4, 1'b0, "R8 reserved edge quiet");
    step(6);

    while (sb.size() != 0) step(1);
    finishRun();
  end

endmodule